// File: doc/BRIEF.md
# Stack Pointer Doubleword Updater

This block rewrites the pointer doubleword of a memory stack when a multi-word pull removes a fixed batch of 28 words. The doubleword carries three fields: a 17-bit top-of-stack address, a 15-bit space count with a sticky overflow flag, and a 15-bit word count with its own status flag. A start strobe captures the current pointer. If the stack holds enough words, the block then walks one word per accepted handshake step. On each step it shows the address of the word being pulled, moves the top address down, lowers the word count and raises the space count.

Alongside the walk, the block gives the two addresses that the effective doubleword is fetched from. For a full stack these lie near the initial top address. For an empty stack they are two fixed real-memory locations. A stack that holds some words but fewer than 28 is left untouched, and the request finishes at once.

Top module: `spd_updater`

## Requirements
- R1: After reset, busy, done, pull_req, use_fixed and ed_valid are 0, and every pointer field output, src_addr and both effective addresses are 0.
- R2: A start seen while idle captures all pointer inputs. If in_words >= 28, busy is 1 from the next cycle. Otherwise busy stays 0, done is 1 in the next cycle, and the field outputs equal the captured inputs unchanged.
- R3: A step is a cycle with busy and step_ack both 1. src_addr shows the current top address before the step, and each step lowers the top address by 1 modulo 2^17.
- R4: Each step lowers the word count by 1. The word flag output always equals the value captured at start; a walk never changes it.
- R5: Each step raises the space count by 1 modulo 2^15. A carry out of bit 14 sets the space flag, and the flag stays set until the next accepted start.
- R6: Exactly 28 steps make a walk. In the cycle after the 28th step, busy is 0 and done is 1, and done is 1 for that one cycle only. The results are then: top = initial-28, words = initial-28, space = initial+28 modulo 2^15, and space flag = initial flag OR (initial space + 28 > 32767).
- R7: A cycle without a step leaves the fields unchanged. This holds for step_ack low while busy and for step_ack high while idle.
- R8: A start that arrives while busy is ignored: the walk and its results are unaffected by the inputs presented with it.
- R9: The effective-address outputs are captured at start. If in_words >= 28: ed_addr_a = initial top-24, ed_addr_b = initial top+1, use_fixed = 0 and ed_valid = 1. If in_words == 0: ed_addr_a = 2, ed_addr_b = 3, use_fixed = 1 and ed_valid = 1. For 1 to 27 words: ed_valid = 0 and use_fixed = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a 28-word pull update |
| in_tos | input | 17 | Current top-of-stack address |
| in_space | input | 15 | Current space count |
| in_space_flag | input | 1 | Current space overflow flag |
| in_words | input | 15 | Current word count |
| in_words_flag | input | 1 | Current word status flag |
| step_ack | input | 1 | One word transferred this cycle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| pull_req | output | 1 | Requests the next word step |
| src_addr | output | 17 | Address of the word pulled this step |
| out_tos | output | 17 | Updated top-of-stack address |
| out_space | output | 15 | Updated space count |
| out_space_flag | output | 1 | Sticky space overflow flag |
| out_words | output | 15 | Updated word count |
| out_words_flag | output | 1 | Word status flag (passed through) |
| ed_addr_a | output | 17 | First effective-doubleword address |
| ed_addr_b | output | 17 | Second effective-doubleword address |
| use_fixed | output | 1 | Effective doubleword comes from fixed locations |
| ed_valid | output | 1 | Effective-address outputs are meaningful |

## Verification
The hardest case to reach is a space-count carry in the middle of a walk while the handshake stalls, followed by a stray start strobe before the 28th step. The stimulus gets there with directed runs whose initial space count lies within 28 of 32767 and whose top address lies near zero, so the carry and the address wrap both fall inside one walk. These runs use random gaps in step_ack and random start pulses with scrambled inputs during the walk. Random runs then spread the word count across zero, the 1 to 27 band, exactly 28, and large values.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {
    ED_NONE  = 2'd0,
    ED_STACK = 2'd1,
    ED_FIXED = 2'd2
  } ed_src_e;

  // Pick the effective-doubleword source from the captured word count.
  function automatic ed_src_e pick_ed_src(input int unsigned words,
                                          input int unsigned batch);
    if (words == 0)          return ED_FIXED;
    else if (words >= batch) return ED_STACK;
    else                     return ED_NONE;
  endfunction
endpackage

// File: rtl/spd_step_ctr.sv
module spd_step_ctr #(
  parameter int BATCH = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic walk_go,
  input  logic finish_now,
  input  logic step,
  output logic busy,
  output logic last_step,
  output logic done
);
  localparam int CW = $clog2(BATCH + 1);
  localparam logic [CW-1:0] LAST = CW'(BATCH - 1);

  logic [CW-1:0] cnt_q;

  assign last_step = step && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= last_step || finish_now;
      if (walk_go) begin
        cnt_q <= '0;
        busy  <= 1'b1;
      end else if (step) begin
        cnt_q <= cnt_q + CW'(1);
        if (last_step) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spd_fields.sv
module spd_fields #(
  parameter int TOS_W = 17,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [TOS_W-1:0] in_tos,
  input  logic [CNT_W-1:0] in_space,
  input  logic             in_space_flag,
  input  logic [CNT_W-1:0] in_words,
  input  logic             in_words_flag,
  output logic [TOS_W-1:0] tos_q,
  output logic [CNT_W-1:0] space_q,
  output logic             space_flag_q,
  output logic [CNT_W-1:0] words_q,
  output logic             words_flag_q,
  output logic             space_carry
);
  function automatic logic [TOS_W-1:0] tos_down(input logic [TOS_W-1:0] v);
    return v - TOS_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] words_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  // Returns {carry, sum} of a one-step space increment.
  function automatic logic [CNT_W:0] space_up(input logic [CNT_W-1:0] v);
    return {1'b0, v} + (CNT_W+1)'(1);
  endfunction

  logic [CNT_W:0] space_inc;
  assign space_inc   = space_up(space_q);
  assign space_carry = step && space_inc[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q        <= '0;
      space_q      <= '0;
      space_flag_q <= 1'b0;
      words_q      <= '0;
      words_flag_q <= 1'b0;
    end else if (load) begin
      tos_q        <= in_tos;
      space_q      <= in_space;
      space_flag_q <= in_space_flag;
      words_q      <= in_words;
      words_flag_q <= in_words_flag;
    end else if (step) begin
      tos_q        <= tos_down(tos_q);
      words_q      <= words_down(words_q);
      space_q      <= space_inc[CNT_W-1:0];
      space_flag_q <= space_flag_q | space_inc[CNT_W];
    end
  end
endmodule

// File: rtl/spd_ed_sel.sv
module spd_ed_sel
  import spd_pkg::*;
#(
  parameter int TOS_W  = 17,
  parameter int CNT_W  = 15,
  parameter int BATCH  = 28,
  parameter int LO_OFS = 24,
  parameter int HI_OFS = 1,
  parameter int FIX_A  = 2,
  parameter int FIX_B  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOS_W-1:0] in_tos,
  input  logic [CNT_W-1:0] in_words,
  output logic [TOS_W-1:0] ed_addr_a,
  output logic [TOS_W-1:0] ed_addr_b,
  output logic             use_fixed,
  output logic             ed_valid
);
  ed_src_e src;
  assign src = pick_ed_src(int'(in_words), BATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ed_addr_a <= '0;
      ed_addr_b <= '0;
      use_fixed <= 1'b0;
      ed_valid  <= 1'b0;
    end else if (load) begin
      unique case (src)
        ED_STACK: begin
          ed_addr_a <= in_tos - TOS_W'(LO_OFS);
          ed_addr_b <= in_tos + TOS_W'(HI_OFS);
          use_fixed <= 1'b0;
          ed_valid  <= 1'b1;
        end
        ED_FIXED: begin
          ed_addr_a <= TOS_W'(FIX_A);
          ed_addr_b <= TOS_W'(FIX_B);
          use_fixed <= 1'b1;
          ed_valid  <= 1'b1;
        end
        default: begin
          ed_addr_a <= '0;
          ed_addr_b <= '0;
          use_fixed <= 1'b0;
          ed_valid  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/spd_updater.sv
module spd_updater #(
  parameter int TOS_W  = 17,
  parameter int CNT_W  = 15,
  parameter int BATCH  = 28,
  parameter int LO_OFS = 24,
  parameter int HI_OFS = 1,
  parameter int FIX_A  = 2,
  parameter int FIX_B  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TOS_W-1:0] in_tos,
  input  logic [CNT_W-1:0] in_space,
  input  logic             in_space_flag,
  input  logic [CNT_W-1:0] in_words,
  input  logic             in_words_flag,
  input  logic             step_ack,
  output logic             busy,
  output logic             done,
  output logic             pull_req,
  output logic [TOS_W-1:0] src_addr,
  output logic [TOS_W-1:0] out_tos,
  output logic [CNT_W-1:0] out_space,
  output logic             out_space_flag,
  output logic [CNT_W-1:0] out_words,
  output logic             out_words_flag,
  output logic [TOS_W-1:0] ed_addr_a,
  output logic [TOS_W-1:0] ed_addr_b,
  output logic             use_fixed,
  output logic             ed_valid
);
  // Named internal events, used by the bound checker.
  logic start_accept;
  logic eligible;
  logic walk_go;
  logic finish_now;
  logic step_fire;
  logic last_step;
  logic space_carry;

  assign start_accept = start && !busy;
  assign eligible     = (in_words >= CNT_W'(BATCH));
  assign walk_go      = start_accept && eligible;
  assign finish_now   = start_accept && !eligible;
  assign step_fire    = busy && step_ack;

  spd_step_ctr #(.BATCH(BATCH)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_go    (walk_go),
    .finish_now (finish_now),
    .step       (step_fire),
    .busy       (busy),
    .last_step  (last_step),
    .done       (done)
  );

  spd_fields #(.TOS_W(TOS_W), .CNT_W(CNT_W)) u_fields (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (start_accept),
    .step          (step_fire),
    .in_tos        (in_tos),
    .in_space      (in_space),
    .in_space_flag (in_space_flag),
    .in_words      (in_words),
    .in_words_flag (in_words_flag),
    .tos_q         (out_tos),
    .space_q       (out_space),
    .space_flag_q  (out_space_flag),
    .words_q       (out_words),
    .words_flag_q  (out_words_flag),
    .space_carry   (space_carry)
  );

  spd_ed_sel #(
    .TOS_W(TOS_W), .CNT_W(CNT_W), .BATCH(BATCH),
    .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .FIX_A(FIX_A), .FIX_B(FIX_B)
  ) u_ed (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_accept),
    .in_tos    (in_tos),
    .in_words  (in_words),
    .ed_addr_a (ed_addr_a),
    .ed_addr_b (ed_addr_b),
    .use_fixed (use_fixed),
    .ed_valid  (ed_valid)
  );

  assign pull_req = busy;
  assign src_addr = out_tos;
endmodule

// File: rtl/spd_updater_chk.sv
module spd_updater_chk #(
  parameter int TOS_W = 17,
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_accept,
  input logic             walk_go,
  input logic             step_fire,
  input logic             space_carry,
  input logic             busy,
  input logic             done,
  input logic [TOS_W-1:0] out_tos,
  input logic [CNT_W-1:0] out_space,
  input logic             out_space_flag,
  input logic [CNT_W-1:0] out_words,
  input logic             out_words_flag
);
  localparam logic [TOS_W-1:0] T1 = TOS_W'(1);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);

  AST_WALK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_go |=> busy); // R2
  AST_TOS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> out_tos == $past(out_tos) - T1); // R3
  AST_WORDS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> out_words == $past(out_words) - C1); // R4
  AST_WFLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !start_accept |=> $stable(out_words_flag)); // R4
  AST_SPACE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> out_space == $past(out_space) + C1); // R5
  AST_SFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_space_flag || space_carry) && !start_accept |=> out_space_flag); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire && !start_accept |=> $stable(out_tos) && $stable(out_space)
                                    && $stable(out_words)); // R7
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_accept); // R8
endmodule

bind spd_updater spd_updater_chk #(.TOS_W(TOS_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_accept   (start_accept),
  .walk_go        (walk_go),
  .step_fire      (step_fire),
  .space_carry    (space_carry),
  .busy           (busy),
  .done           (done),
  .out_tos        (out_tos),
  .out_space      (out_space),
  .out_space_flag (out_space_flag),
  .out_words      (out_words),
  .out_words_flag (out_words_flag)
);

// File: tb/spd_updater_test.sv
`timescale 1ns/1ps
module spd_updater_test;
  localparam int TW = 17;
  localparam int CW = 15;
  localparam int N  = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [TW-1:0] in_tos = '0;
  logic [CW-1:0] in_space = '0;
  logic in_space_flag = 1'b0;
  logic [CW-1:0] in_words = '0;
  logic in_words_flag = 1'b0;
  logic step_ack = 1'b0;
  logic busy, done, pull_req, out_space_flag, out_words_flag, use_fixed, ed_valid;
  logic [TW-1:0] src_addr, out_tos, ed_addr_a, ed_addr_b;
  logic [CW-1:0] out_space, out_words;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spd_updater uut (.*);

  function automatic logic [TW-1:0] exp_tos(input logic [TW-1:0] t, input int k);
    return TW'((int'(t) - k) & ((1 << TW) - 1));
  endfunction
  function automatic logic [CW-1:0] exp_sp(input logic [CW-1:0] s, input int k);
    return CW'((int'(s) + k) % (1 << CW));
  endfunction
  function automatic logic exp_spf(input logic [CW-1:0] s, input logic f, input int k);
    return f | ((int'(s) + k) > 32767);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [TW-1:0] t, input logic [CW-1:0] s, input logic sf,
                     input logic [CW-1:0] w, input logic wf, input int ack_pct,
                     input bit poke);
    int k;
    @(negedge clk);
    in_tos = t; in_space = s; in_space_flag = sf; in_words = w; in_words_flag = wf;
    start = 1'b1; step_ack = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (w >= CW'(N)) begin
      chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(ed_valid && !use_fixed, "R9 stack src", {use_fixed, ed_valid}, 1);
      chk(ed_addr_a == exp_tos(t, 24), "R9 ed_a", ed_addr_a, exp_tos(t, 24));
      chk(ed_addr_b == exp_tos(t, -1), "R9 ed_b", ed_addr_b, exp_tos(t, -1));
      k = 0;
      while (k < N) begin
        chk(busy && pull_req && !done, "R6 busy mid", busy, 1);
        chk(src_addr == exp_tos(t, k), "R3 src/tos", src_addr, exp_tos(t, k));
        chk(out_words == CW'(int'(w) - k), "R4 words", out_words, int'(w) - k);
        chk(out_words_flag == wf, "R4 wflag", out_words_flag, wf);
        chk(out_space == exp_sp(s, k), "R5 space", out_space, exp_sp(s, k));
        chk(out_space_flag == exp_spf(s, sf, k), "R5 sflag", out_space_flag,
            exp_spf(s, sf, k));
        step_ack = (($urandom % 100) < ack_pct);
        if (poke && (($urandom % 4) == 0)) begin
          start = 1'b1;
          in_tos = TW'($urandom); in_words = CW'($urandom); in_space = CW'($urandom);
          in_space_flag = ~sf; in_words_flag = ~wf;
        end
        @(negedge clk);
        start = 1'b0;
        if (step_ack) k++;
      end
      step_ack = 1'b0;
      chk(done && !busy, "R6 done after 28", {done, busy}, 2);
      chk(out_tos == exp_tos(t, N), "R6/R8 final tos", out_tos, exp_tos(t, N));
      chk(out_words == CW'(int'(w) - N), "R6/R8 final words", out_words, int'(w) - N);
      chk(out_space == exp_sp(s, N), "R6/R8 final space", out_space, exp_sp(s, N));
      chk(out_space_flag == exp_spf(s, sf, N), "R6 final sflag", out_space_flag,
          exp_spf(s, sf, N));
      chk(out_words_flag == wf, "R8 wflag", out_words_flag, wf);
      step_ack = 1'b1;
      @(negedge clk);
      step_ack = 1'b0;
      chk(!done, "R6 done one cycle", done, 0);
      chk(out_tos == exp_tos(t, N) && out_words == CW'(int'(w) - N),
          "R7 idle ack ignored", out_tos, exp_tos(t, N));
    end else begin
      chk(!busy && done, "R2 short no walk", {busy, done}, 1);
      chk(out_tos == t && out_words == w && out_space == s && out_space_flag == sf
          && out_words_flag == wf, "R2 unchanged", out_tos, t);
      chk(use_fixed == (w == 0) && ed_valid == (w == 0), "R9 flags",
          {use_fixed, ed_valid}, (w == 0) ? 3 : 0);
      if (w == 0) begin
        chk(ed_addr_a == 2 && ed_addr_b == 3, "R9 fixed addr", ed_addr_a, 2);
      end
      step_ack = 1'b1;
      @(negedge clk);
      step_ack = 1'b0;
      chk(!done && out_tos == t && out_space == s, "R7 idle ack", out_tos, t);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pull_req && !use_fixed && !ed_valid, "R1 ctrl", busy, 0);
    chk(out_tos == 0 && out_space == 0 && out_words == 0 && !out_space_flag
        && !out_words_flag && src_addr == 0 && ed_addr_a == 0 && ed_addr_b == 0,
        "R1 fields", out_tos, 0);
    rst_n = 1'b1;
    // Directed corners
    run(17'd1000, 15'd100, 1'b0, 15'd28, 1'b0, 100, 0);
    run(17'd10, 15'd32750, 1'b0, 15'd40, 1'b1, 60, 1);
    run(17'd5, 15'd32767, 1'b1, 15'd32767, 1'b1, 40, 1);
    run(17'd300, 15'd7, 1'b0, 15'd0, 1'b0, 100, 0);
    run(17'd300, 15'd7, 1'b1, 15'd27, 1'b1, 100, 0);
    run(17'd3, 15'd0, 1'b0, 15'd1, 1'b0, 100, 0);
    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [CW-1:0] w;
      case ($urandom % 4)
        0: w = CW'(0);
        1: w = CW'($urandom % 28);
        2: w = CW'(28 + ($urandom % 4));
        default: w = CW'($urandom);
      endcase
      run(TW'($urandom), CW'($urandom), 1'($urandom), w, 1'($urandom),
          30 + ($urandom % 71), 1'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule